// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Aggregator

This block folds 32 interrupt sources into one CPU interrupt line. Each source position has a fixed type. A level position shows its synchronized input as it is. An edge position holds a sticky latch that a rising input edge sets. A software position holds a latch that software sets and clears. Three level positions take the summary lines of a secondary peripheral controller, so a whole group of cascaded sources appears as one bit here.

Software reaches the block through a small synchronous register bus. The status word merges level inputs and latches. An enable word masks it. A hard word holds the latches. Software acknowledges an edge source by writing the hard word back with that one bit at zero. The block also gives the index of the lowest-numbered enabled pending source, with a valid flag, so a handler can dispatch without scanning the word.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable word, every latch, `cpu_irq_o`, `vec_valid_o` and `vec_idx_o` are zero.
- R2: A level position shows its input in the status word two clock edges after the input changes. Level positions are every bit except 22–24 and 28–30; bits 4 (super-I/O group), 5 (miscellaneous group) and 6 (audio group) are level positions for the secondary controller summaries. Writes to the hard word have no effect on level positions.
- R3: A rising edge on input bit 22, 23 or 24 sets that bit's latch, and the latch stays set after the input falls.
- R4: Writing the hard word with a zero in bit 22, 23 or 24 clears that latch; a one leaves it unchanged.
- R5: If a new rising edge reaches a hardware edge latch in the same cycle as a write that clears it, the latch stays set.
- R6: Software bits 28–30 take the written value on a hard-word write: a one sets the latch and a zero clears it. Their input pins have no effect.
- R7: `cpu_irq_o` is the OR of status AND enable, registered one cycle after the status word.
- R8: `vec_idx_o` is the lowest index set in status AND enable, and `vec_valid_o` is low when none is set. Both are registered in the same cycle as `cpu_irq_o`.
- R9: Register map, read data one cycle after the access: address 0 status (read only), 1 enable (read/write), 2 hard word (reads the latches, level positions read zero), 3 vector (bit 31 valid, bits 4:0 index).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Raw interrupt source lines, asynchronous |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| cpu_irq_o | output | 1 | Interrupt line to the CPU |
| vec_valid_o | output | 1 | An enabled source is pending |
| vec_idx_o | output | 5 | Index of the lowest enabled pending source |

## Verification
Random source words change level and edge positions together. Each change is followed by random enable writes and random hard-word writes. This separates the sticky latches from the level pass-through. It also shows write-one-keeps apart from write-zero-clears, and the set-by-one software behaviour apart from hardware acknowledgement. Directed cases count the synchronizer and output latency exactly. They check that the lowest enabled index wins when several bits are pending. They also drive a rising edge into the very cycle of a clearing write, which tells an edge-wins latch from one where the clear wins.

// File: rtl/irq_agg_pkg.sv
// Shared definitions for the interrupt aggregator: register addresses.
package irq_agg_pkg;

    // Register addresses on the synchronous access bus.
    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_HARD   = 2'd2,
        REG_VECTOR = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/irq_src_sync.sv
// Two-flop synchronizer per source line plus a delayed copy for rising-edge
// detection. Assumes inputs are asynchronous single-bit lines.
module irq_src_sync #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] sync_o,
    output logic [NUM_SRC-1:0] rise_o
);

    logic [NUM_SRC-1:0] meta_q;
    logic [NUM_SRC-1:0] sync_q;
    logic [NUM_SRC-1:0] prev_q;

    // Synchronizer chain and one-cycle delayed copy.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= src_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Rising edge seen on the synchronized line this cycle.
    always_comb begin
        sync_o = sync_q;
        rise_o = sync_q & ~prev_q;
    end

endmodule

// File: rtl/irq_latch_bank.sv
// Per-bit latch bank. A generate picks the variant of each position:
// hardware edge latch, software latch, or none (level positions read zero).
// Assumes one write strobe for the whole hard word.
module irq_latch_bank #(
    parameter int                 NUM_SRC  = 32,
    parameter logic [NUM_SRC-1:0] HW_BITS  = 32'h01C0_0000,
    parameter logic [NUM_SRC-1:0] SW_BITS  = 32'h7000_0000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] latch_o
);

    for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
        if (HW_BITS[b]) begin : g_hw
            logic lat_q;
            logic clr;
            // A write of zero acknowledges; a write of one keeps the bit.
            always_comb clr = wr_i && !wdata_i[b];
            // Sticky edge latch; a fresh edge wins over a clear.
            always_ff @(posedge clk_i) begin
                if (!rst_ni)        lat_q <= 1'b0;
                else if (rise_i[b]) lat_q <= 1'b1;
                else if (clr)       lat_q <= 1'b0;
            end
            assign latch_o[b] = lat_q;
        end else if (SW_BITS[b]) begin : g_sw
            logic lat_q;
            // Software latch loads the written value.
            always_ff @(posedge clk_i) begin
                if (!rst_ni)   lat_q <= 1'b0;
                else if (wr_i) lat_q <= wdata_i[b];
            end
            assign latch_o[b] = lat_q;
        end else begin : g_lvl
            assign latch_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_lowest_enc.sv
// Lowest-index priority encoder. Assumes NUM_SRC >= 2.
module irq_lowest_enc #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] vec_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from the top so the lowest set index is kept last.
    always_comb begin
        idx_o   = '0;
        valid_o = |vec_i;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
// Interrupt aggregator top: merges level inputs and edge/software latches
// into a status word, masks it with an enable word, and drives a registered
// CPU line and lowest-pending vector. Register bus reads have one cycle of
// latency. Assumes NUM_SRC equals the bus width and NUM_SRC > IDX_W.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int                 NUM_SRC = 32,
    parameter logic [NUM_SRC-1:0] HW_BITS = 32'h01C0_0000,
    parameter logic [NUM_SRC-1:0] SW_BITS = 32'h7000_0000,
    localparam int                IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [1:0]         bus_addr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               cpu_irq_o,
    output logic               vec_valid_o,
    output logic [IDX_W-1:0]   vec_idx_o
);

    localparam logic [NUM_SRC-1:0] LEVEL_BITS = ~(HW_BITS | SW_BITS);

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] src_rise;
    logic [NUM_SRC-1:0] latch_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] status_w;
    logic [NUM_SRC-1:0] pend_w;
    logic               enc_valid;
    logic [IDX_W-1:0]   enc_idx;
    logic               hard_we;
    logic               enable_we;
    logic               rd_en;

    // Decode bus strobes.
    always_comb begin
        hard_we   = bus_sel_i &&  bus_we_i && (reg_addr_e'(bus_addr_i) == REG_HARD);
        enable_we = bus_sel_i &&  bus_we_i && (reg_addr_e'(bus_addr_i) == REG_ENABLE);
        rd_en     = bus_sel_i && !bus_we_i;
    end

    irq_src_sync #(
        .NUM_SRC (NUM_SRC)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i),
        .sync_o (src_sync),
        .rise_o (src_rise)
    );

    irq_latch_bank #(
        .NUM_SRC (NUM_SRC),
        .HW_BITS (HW_BITS),
        .SW_BITS (SW_BITS)
    ) u_latch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rise_i  (src_rise),
        .wr_i    (hard_we),
        .wdata_i (bus_wdata_i),
        .latch_o (latch_q)
    );

    // Merge level inputs with latches and apply the enable word.
    always_comb begin
        status_w = (src_sync & LEVEL_BITS) | latch_q;
        pend_w   = status_w & enable_q;
    end

    irq_lowest_enc #(
        .NUM_SRC (NUM_SRC)
    ) u_enc (
        .vec_i   (pend_w),
        .valid_o (enc_valid),
        .idx_o   (enc_idx)
    );

    // Enable register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        enable_q <= '0;
        else if (enable_we) enable_q <= bus_wdata_i;
    end

    // Registered CPU line and dispatch vector.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cpu_irq_o   <= 1'b0;
            vec_valid_o <= 1'b0;
            vec_idx_o   <= '0;
        end else begin
            cpu_irq_o   <= |pend_w;
            vec_valid_o <= enc_valid;
            vec_idx_o   <= enc_idx;
        end
    end

    // Registered read data mux.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bus_rdata_o <= '0;
        end else if (rd_en) begin
            unique case (reg_addr_e'(bus_addr_i))
                REG_STATUS: bus_rdata_o <= status_w;
                REG_ENABLE: bus_rdata_o <= enable_q;
                REG_HARD:   bus_rdata_o <= latch_q;
                REG_VECTOR: begin
                    bus_rdata_o              <= '0;
                    bus_rdata_o[NUM_SRC-1]   <= vec_valid_o;
                    bus_rdata_o[IDX_W-1:0]   <= vec_idx_o;
                end
                default:    bus_rdata_o <= '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
// Property checker for irq_aggregator, attached by bind below.
module irq_aggregator_chk #(
    parameter int                 NUM_SRC = 32,
    parameter logic [NUM_SRC-1:0] HW_BITS = 32'h01C0_0000,
    parameter logic [NUM_SRC-1:0] SW_BITS = 32'h7000_0000,
    localparam int                IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               hard_we_i,
    input logic [NUM_SRC-1:0] wdata_i,
    input logic [NUM_SRC-1:0] rise_i,
    input logic [NUM_SRC-1:0] latch_i,
    input logic [NUM_SRC-1:0] pend_i,
    input logic               cpu_irq_i,
    input logic               vec_valid_i,
    input logic [IDX_W-1:0]   vec_idx_i
);

    // R3: without a hard write, no hardware edge latch falls.
    a_r3_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hard_we_i |=> (($past(latch_i) & ~latch_i & HW_BITS) == '0));

    // R5: an edge coinciding with a clearing write keeps the latch set.
    a_r5_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hard_we_i && ((rise_i & HW_BITS) != '0))
        |=> ((latch_i & $past(rise_i & HW_BITS)) == $past(rise_i & HW_BITS)));

    // R6: software latches take the written value.
    a_r6_soft_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hard_we_i |=> ((latch_i & SW_BITS) == ($past(wdata_i) & SW_BITS)));

    // R7: CPU line and vector valid agree.
    a_r7_irq_valid_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_irq_i == vec_valid_i);

    // R8: the reported index was pending and nothing below it was.
    a_r8_index_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_i |-> ((($past(pend_i) >> vec_idx_i) & NUM_SRC'(1)) != '0)
                        && (($past(pend_i) & ((NUM_SRC'(1) << vec_idx_i) - NUM_SRC'(1))) == '0));

    // R8: valid low only when nothing was pending.
    a_r8_none_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_valid_i |-> ($past(pend_i) == '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .NUM_SRC (NUM_SRC),
    .HW_BITS (HW_BITS),
    .SW_BITS (SW_BITS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hard_we_i   (hard_we),
    .wdata_i     (bus_wdata_i),
    .rise_i      (src_rise),
    .latch_i     (latch_q),
    .pend_i      (pend_w),
    .cpu_irq_i   (cpu_irq_o),
    .vec_valid_i (vec_valid_o),
    .vec_idx_i   (vec_idx_o)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

    localparam logic [31:0] HW  = 32'h01C0_0000;
    localparam logic [31:0] SW  = 32'h7000_0000;
    localparam logic [31:0] LVL = ~(HW | SW);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        vvalid;
    logic [4:0]  vidx;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_lat = '0;
    logic [31:0] m_en  = '0;

    always #4 clk = ~clk;

    irq_aggregator u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .cpu_irq_o   (irq),
        .vec_valid_o (vvalid),
        .vec_idx_o   (vidx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk); d = rdata; sel = 1'b0;
    endtask

    function automatic logic [31:0] exp_status();
        return (src & LVL) | m_lat;
    endfunction

    function automatic logic [31:0] exp_vector();
        logic [31:0] p = exp_status() & m_en;
        for (int i = 0; i < 32; i++) if (p[i]) return 32'h8000_0000 | 32'(i);
        return 32'h0;
    endfunction

    // Hard-word write as the requirements define it (R4, R6).
    function automatic void model_hard_write(input logic [31:0] d);
        m_lat = (m_lat & HW & d) | (d & SW);
    endfunction

    task automatic full_check(input string tag);
        logic [31:0] d;
        rd(2'd0, d); chk({tag, " R2 R3 status"}, d, exp_status());
        rd(2'd2, d); chk({tag, " R9 hard"}, d, m_lat);
        rd(2'd3, d); chk({tag, " R8 vector"}, d, exp_vector());
        chk({tag, " R7 irq"}, 32'(irq), 32'((exp_status() & m_en) != 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 valid", 32'(vvalid), 32'd0);
        chk("R1 idx", 32'(vidx), 32'd0);
        rd(2'd1, d); chk("R1 enable", d, 32'd0);
        rd(2'd2, d); chk("R1 hard", d, 32'd0);

        // R7/R2: latency of a level bit through sync and output register.
        wr(2'd1, 32'h0000_0008); m_en = 32'h0000_0008;
        @(negedge clk); src[3] = 1'b1;
        @(negedge clk); chk("R7 latency edge1", 32'(irq), 32'd0);
        @(negedge clk); chk("R7 latency edge2", 32'(irq), 32'd0);
        @(negedge clk); chk("R7 latency edge3", 32'(irq), 32'd1);

        // R2: hard write of zeros leaves level bits (incl. group summaries 4..6).
        src[6:4] = 3'b101;
        repeat (3) @(negedge clk);
        wr(2'd2, 32'h0); model_hard_write(32'h0);
        rd(2'd0, d); chk("R2 level after hard write", d, exp_status());

        // R3: edge on bit 23 stays latched after input falls.
        src[23] = 1'b1; repeat (4) @(negedge clk);
        src[23] = 1'b0; repeat (4) @(negedge clk);
        m_lat[23] = 1'b1;
        rd(2'd2, d); chk("R3 sticky", d, m_lat);

        // R4: write one keeps, write zero clears.
        wr(2'd2, 32'h0080_0000); model_hard_write(32'h0080_0000);
        rd(2'd2, d); chk("R4 write one keeps", d, m_lat);
        wr(2'd2, 32'h0); model_hard_write(32'h0);
        rd(2'd2, d); chk("R4 write zero clears", d, 32'h0);

        // R6: software bits set by one, cleared by zero; pins ignored.
        src[29] = 1'b1; repeat (4) @(negedge clk);
        rd(2'd0, d); chk("R6 pin ignored", d, exp_status());
        wr(2'd2, 32'h5000_0000); model_hard_write(32'h5000_0000);
        rd(2'd2, d); chk("R6 set", d, 32'h5000_0000);
        wr(2'd2, 32'h4000_0000); model_hard_write(32'h4000_0000);
        rd(2'd2, d); chk("R6 clear", d, 32'h4000_0000);
        src[29] = 1'b0;

        // R5: rising edge lands in the cycle of a clearing write.
        wr(2'd2, 32'h0); model_hard_write(32'h0);
        @(negedge clk); src[22] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); sel = 1'b1; we = 1'b1; addr = 2'd2; wdata = 32'h8FBF_FFFF;
        @(negedge clk); sel = 1'b0; we = 1'b0;
        m_lat = 32'h0040_0000;
        rd(2'd2, d); chk("R5 edge wins", d, m_lat);
        src[22] = 1'b0;

        // R8: several pending, lowest enabled wins.
        wr(2'd1, 32'h0140_0060); m_en = 32'h0140_0060;
        repeat (2) @(negedge clk);
        rd(2'd3, d); chk("R8 lowest", d, exp_vector());
        wr(2'd1, 32'h0040_0000); m_en = 32'h0040_0000;
        rd(2'd3, d); chk("R8 only edge", d, 32'h8000_0016);

        // Random phase: R2 R3 R4 R6 R7 R8 R9 against the model.
        for (int it = 0; it < 60; it++) begin
            logic [31:0] nsrc = $urandom;
            logic [31:0] v = $urandom;
            m_lat = m_lat | (~src & nsrc & HW);
            @(negedge clk); src = nsrc;
            repeat (4) @(negedge clk);
            case ($urandom % 3)
                0: begin wr(2'd1, v); m_en = v; end
                1: begin wr(2'd2, v); model_hard_write(v); end
                default: ;
            endcase
            rd(2'd1, d); chk("R9 enable readback", d, m_en);
            full_check("random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule